// File: doc/BRIEF.md
# Isochronous Cycle Event Monitor

This block sits beside a free-running isochronous cycle timer and the packet engine. It turns their raw strobes into the cycle-related interrupt events. Five events leave the block as one-cycle pulses: seconds tick, cycle-start seen, cycle done, cycle lost and cycle-start arbitration failure. A sixth output, cycle pending, is a level. It covers the span from a cycle-offset wrap to the end of that isochronous period. An interrupt status register elsewhere latches the pulses.

The monitor counts offset wraps that pass without a cycle-start packet and reports a lost cycle when that count reaches a threshold. It also remembers whether a cycle-start has been seen, so the first arbitration gap after it closes the period. Every output is registered, so it appears one clock after the input condition that causes it.

Top module: `cyc_mon`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset, all six outputs are 0. Reset clears the wrap counter, the armed flag and pending.
- R2: cyc_sec_o pulses high for one cycle, one clock after sec_inc_i is high.
- R3: cyc_start_o pulses high one clock after cs_tx_i or cs_rx_i is high. Either source alone is enough.
- R4: cyc_arb_fail_o pulses high one clock after cs_arb_fail_i is high.
- R5: cyc_pend_o goes high one clock after roll_i. It stays high until the done condition is met, and falls in the same cycle that cyc_done_o pulses.
- R6: cyc_done_o pulses one clock after the first arb_gap_i that follows a cycle-start. Later gaps give no pulse until the next cycle-start, and a gap with no cycle-start before it is ignored. A cycle-start and a gap in the same cycle close any earlier armed period and arm a new one.
- R7: With LOST_ROLLS=2, cyc_lost_o pulses one clock after the second roll_i with no cycle-start in between. A cycle-start clears the wrap count, and this includes a cycle-start in the same cycle as a roll.
- R8: After a cyc_lost_o pulse the wrap count restarts from 0, so the next pulse needs LOST_ROLLS further wraps.
- R9: A roll_i while cyc_pend_o is high keeps it high with no fall. A roll_i in the same cycle as the done condition also keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| roll_i | input | 1 | Cycle offset wrapped to 0 (rollover or timer reset) |
| sec_inc_i | input | 1 | Seconds count incremented |
| cs_tx_i | input | 1 | Cycle-start packet transmitted |
| cs_rx_i | input | 1 | Cycle-start packet received |
| arb_gap_i | input | 1 | Arbitration gap detected on the bus |
| cs_arb_fail_i | input | 1 | Arbitration for cycle-start failed |
| cyc_sec_o | output | 1 | Seconds tick pulse |
| cyc_start_o | output | 1 | Cycle-start seen pulse |
| cyc_done_o | output | 1 | Cycle done pulse |
| cyc_lost_o | output | 1 | Cycle lost pulse |
| cyc_arb_fail_o | output | 1 | Cycle-start arbitration failure pulse |
| cyc_pend_o | output | 1 | Cycle pending level |

## Verification
The hardest situations to reach are the collisions: a roll landing in the same cycle as a done condition or a lost threshold, and a cycle-start arriving together with a gap or a roll. In those cycles the priority between setting and clearing decides the outputs. The stimulus table walks through plain sequences first to build up the counter and armed state. It then drives the colliding strobes on the exact cycle where that state is ready. Directed tests afterwards repeat wraps inside a pending period and apply reset in the middle of a period.

// File: rtl/cyc_mon_pkg.sv
package cyc_mon_pkg;
  typedef struct packed {
    logic sec;
    logic start;
    logic arb_fail;
  } cyc_strb_t;

  localparam int unsigned STRB_W = $bits(cyc_strb_t);
endpackage

// File: rtl/cyc_mon_pulse_reg.sv
module cyc_mon_pulse_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[g] <= 1'b0;
      else         q_o[g] <= d_i[g];
    end
  end
endmodule

// File: rtl/cyc_mon_lost.sv
module cyc_mon_lost #(
  parameter int unsigned LOST_ROLLS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic roll_i,
  input  logic cs_i,
  output logic lost_o
);
  localparam int unsigned CNT_W = (LOST_ROLLS > 2) ? $clog2(LOST_ROLLS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOST_ROLLS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = roll_i && !cs_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lost_o <= 1'b0;
    end else begin
      lost_o <= hit;
      // cycle-start wins over a coincident roll
      if (cs_i)        cnt_q <= '0;
      else if (hit)    cnt_q <= '0;
      else if (roll_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_lost_after_roll_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lost_o) |-> $past(roll_i) && !$past(cs_i));
  p_lost_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> cnt_q == '0);
endmodule

// File: rtl/cyc_mon_period.sv
module cyc_mon_period (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic roll_i,
  input  logic cs_i,
  input  logic gap_i,
  output logic done_o,
  output logic pend_o
);
  logic armed_q;
  logic done_c;

  assign done_c = gap_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      done_o  <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      done_o  <= done_c;
      armed_q <= cs_i || (armed_q && !gap_i);
      // roll sets pending and outranks a coincident done
      pend_o  <= roll_i || (pend_o && !done_c);
    end
  end

  p_done_needs_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(armed_q) && $past(gap_i));
  p_pend_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(roll_i));
  p_pend_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_o) |-> done_o);
  p_pend_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_i |=> pend_o);
endmodule

// File: rtl/cyc_mon.sv
module cyc_mon
  import cyc_mon_pkg::*;
#(
  parameter int unsigned LOST_ROLLS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic roll_i,
  input  logic sec_inc_i,
  input  logic cs_tx_i,
  input  logic cs_rx_i,
  input  logic arb_gap_i,
  input  logic cs_arb_fail_i,
  output logic cyc_sec_o,
  output logic cyc_start_o,
  output logic cyc_done_o,
  output logic cyc_lost_o,
  output logic cyc_arb_fail_o,
  output logic cyc_pend_o
);
  logic      cs_seen;
  cyc_strb_t strb_d, strb_q;

  assign cs_seen = cs_tx_i || cs_rx_i;

  always_comb begin
    strb_d.sec      = sec_inc_i;
    strb_d.start    = cs_seen;
    strb_d.arb_fail = cs_arb_fail_i;
  end

  cyc_mon_pulse_reg #(.W(STRB_W)) u_strb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (strb_d),
    .q_o    (strb_q)
  );

  assign cyc_sec_o      = strb_q.sec;
  assign cyc_start_o    = strb_q.start;
  assign cyc_arb_fail_o = strb_q.arb_fail;

  cyc_mon_lost #(.LOST_ROLLS(LOST_ROLLS)) u_lost (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .roll_i (roll_i),
    .cs_i   (cs_seen),
    .lost_o (cyc_lost_o)
  );

  cyc_mon_period u_period (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .roll_i (roll_i),
    .cs_i   (cs_seen),
    .gap_i  (arb_gap_i),
    .done_o (cyc_done_o),
    .pend_o (cyc_pend_o)
  );

  p_start_follows_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_tx_i || cs_rx_i) |=> cyc_start_o);
  p_sec_follows_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_sec_o |-> $past(sec_inc_i));
  p_af_follows_fail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_arb_fail_o |-> $past(cs_arb_fail_i));
endmodule

// File: tb/cyc_mon_bench.sv
module cyc_mon_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic roll = 0, sec = 0, tx = 0, rx = 0, gap = 0, af = 0;
  logic o_sec, o_start, o_done, o_lost, o_af, o_pend;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cyc_mon u_cyc_mon (
    .clk_i(clk), .rst_ni(rst_n), .roll_i(roll), .sec_inc_i(sec),
    .cs_tx_i(tx), .cs_rx_i(rx), .arb_gap_i(gap), .cs_arb_fail_i(af),
    .cyc_sec_o(o_sec), .cyc_start_o(o_start), .cyc_done_o(o_done),
    .cyc_lost_o(o_lost), .cyc_arb_fail_o(o_af), .cyc_pend_o(o_pend)
  );

  // stim {roll,sec,tx,rx,gap,af} , expect {sec,start,done,lost,af,pend}
  localparam int N = 21;
  localparam logic [11:0] VEC [N] = '{
    {6'b010000, 6'b100000}, // R2
    {6'b000001, 6'b000010}, // R4
    {6'b000010, 6'b000000}, // R6 unarmed gap
    {6'b100000, 6'b000001}, // R5
    {6'b001000, 6'b010001}, // R3 tx
    {6'b000010, 6'b001000}, // R6 done, pend falls
    {6'b000010, 6'b000000}, // R6 extra gap ignored
    {6'b100000, 6'b000001},
    {6'b100000, 6'b000101}, // R7 lost, R9
    {6'b100000, 6'b000001}, // R8 restart
    {6'b000100, 6'b010001}, // R3 rx
    {6'b100000, 6'b000001},
    {6'b100010, 6'b001101}, // R9 roll with done, R7
    {6'b000010, 6'b000001},
    {6'b100000, 6'b000001},
    {6'b100100, 6'b010001}, // R7 cs clears on roll cycle
    {6'b100000, 6'b000001},
    {6'b000110, 6'b011000}, // R6 cs+gap
    {6'b000010, 6'b001000},
    {6'b010001, 6'b100010},
    {6'b000000, 6'b000000}
  };

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input logic [5:0] e, input string tag);
    chk(o_sec,   e[5], {"R2 ", tag});
    chk(o_start, e[4], {"R3 ", tag});
    chk(o_done,  e[3], {"R6 ", tag});
    chk(o_lost,  e[2], {"R7 ", tag});
    chk(o_af,    e[1], {"R4 ", tag});
    chk(o_pend,  e[0], {"R5 ", tag});
  endtask

  task automatic drive(input logic [5:0] s);
    {roll, sec, tx, rx, gap, af} = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all(6'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all(6'b0, "R1 after reset");

    for (int i = 0; i < N; i++) begin
      drive(VEC[i][11:6]);
      @(negedge clk);
      chk_all(VEC[i][5:0], $sformatf("vec %0d", i));
    end

    // R9: repeated wraps inside one pending span, pending never falls
    drive(6'b001000); @(negedge clk);          // arm, clears count
    for (int k = 0; k < 4; k++) begin
      drive(6'b100000); @(negedge clk);
      chk(o_pend, 1'b1, "R9 pend held");
      chk(o_lost, (k % 2) == 1, "R8 lost every second wrap");
    end
    drive(6'b000000); @(negedge clk);
    chk(o_pend, 1'b1, "R9 pend stays without done");

    // R1: reset mid-period
    drive(6'b111111);
    #2 rst_n = 1'b0;
    @(negedge clk);
    chk_all(6'b0, "R1 mid reset");
    drive(6'b000000);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all(6'b0, "R1 post reset idle");
    // armed flag cleared by reset: gap gives no done (R1, R6)
    drive(6'b000010); @(negedge clk);
    chk(o_done, 1'b0, "R1 armed cleared");
    // count cleared by reset: one wrap gives no lost (R1, R7)
    drive(6'b100000); @(negedge clk);
    chk(o_lost, 1'b0, "R1 count cleared");
    drive(6'b000000); @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule